// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets a host microcontroller read and write a bank of 8-bit configuration registers over a four-wire serial link. The wires are a serial clock, host-to-slave data, slave-to-host data and an active-low configuration select. Each access is a two-byte frame. The first byte is a header. It holds a leading zero, a direction flag, a five-bit register index and a trailing one. The second byte carries the value to store, or it is the window in which the slave returns the register's contents. A write always returns the register's previous contents in the same byte. While the select stays low, any number of frames may follow one another, and bytes alternate between header and payload.

The link pins are sampled with the block's own system clock through a two-stage synchronizer. The serial clock must therefore run well below the system clock; about a tenth of it or slower is comfortable. The slave-to-host pin comes with an output enable, so that a pad can release the line while the block is not selected.

A second active-low select, for a data path outside this block, is also taken in. When both selects are low, the configuration port keeps the link.

Top module: `cfg_spi_slave`

## Requirements
- R1: A header byte is, most significant bit first: bit 7 start (must be 0), bit 6 direction (1 = read, 0 = write), bits 5..1 register index (bit 5 is the index MSB), bit 0 stop (must be 1).
- R2: In a write frame, the payload byte (MSB first) is stored at the indexed register once its eighth bit is sampled. The new value is returned by any later frame.
- R3: In a read frame, the indexed register is shifted out on `miso`, MSB first, during the payload byte. `mosi` is sampled on rising `sck` and `miso` changes only on falling `sck`.
- R4: In a write frame, `miso` carries the register's previous contents, MSB first, during the payload byte.
- R5: Raising `cfg_sel_n`, after a header or in the middle of any byte, drops the partial frame. The next byte received is a header.
- R6: With `cfg_sel_n` held low, frames chain back to back, with bytes taken alternately as header and payload.
- R7: `dat_sel_n` has no effect: configuration accesses behave the same whether it is high or low.
- R8: If a header has a wrong start bit or stop bit, its payload byte writes nothing and `miso` stays 0 during it. The following byte is still a header.
- R9: `miso_en` is 0 while `cfg_sel_n` is high and 1 while it is low.
- R10: After reset, all 32 registers read as zero.
- R11: The payload byte of a read frame never changes the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the link |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| cfg_sel_n | input | 1 | Active-low configuration select |
| dat_sel_n | input | 1 | Active-low select of the external data path |
| miso | output | 1 | Serial data to the host |
| miso_en | output | 1 | Drive enable for the `miso` pad |

## Verification
The bench builds the block with its default parameters: a 5-bit index, 8-bit registers and a two-stage synchronizer. At these values every one of the 32 registers can be reached, including indices 0 and 31 at the edges of the index field. The serial clock runs at one twentieth of the system clock, so synchronizer latency never hides a bit. This exposes the exact edge on which the old contents appear and the new value is committed. Bad start and stop bits, deselection after a header or mid-byte, and chained frames are all driven, and `dat_sel_n` is held low during live traffic.

// File: rtl/cfg_spi_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial configuration slave.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cfg_spi_pkg;

    // Which half of a two-byte frame is being received.
    typedef enum logic {
        PH_HDR  = 1'b0,
        PH_PAY  = 1'b1
    } phase_e;

    // Port arbitration: the configuration request wins whenever it is
    // asserted; the data request only matters when it is not.
    function automatic logic cfg_grant(input logic cfg_req, input logic dat_req);
        return cfg_req & (cfg_req | ~dat_req);
    endfunction

endpackage

// File: rtl/cfg_spi_sync.sv
`timescale 1ns/1ps
// Multi-bit input synchronizer: each bit passes STAGES flops.
// Assumes every bit is an independent slow level (no bus coherence needed).
module cfg_spi_sync #(
    parameter int            W       = 4,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    // Chain of capture flops, reset to the idle level of each pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_spi_edge.sv
`timescale 1ns/1ps
// Edge detector on the synchronized serial clock.
// Assumes the input is already in the clk domain.
module cfg_spi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_q;

    // Remember last level to find transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/cfg_spi_framer.sv
`timescale 1ns/1ps
// Frame parser: counts bits, alternates header/payload, decodes the
// header and raises a one-cycle write strobe on the last payload bit.
// Assumes 'rise' is a single-cycle strobe and 'sel' is synchronized.
module cfg_spi_framer
    import cfg_spi_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int HDR_W = ADDR_W + 3,
    localparam int SH_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W,
    localparam int CW    = $clog2(SH_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              mosi_bit,
    output phase_e            phase,
    output logic [CW-1:0]     cnt,
    output logic              hdr_ok,
    output logic              hdr_rw,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);
    logic [SH_W-2:0]  shreg_q;
    logic [HDR_W-1:0] hdr_word;
    logic             hdr_last;
    logic             pay_last;

    assign hdr_word = {shreg_q[HDR_W-2:0], mosi_bit};
    assign wr_data  = {shreg_q[DATA_W-2:0], mosi_bit};
    assign hdr_last = (phase == PH_HDR) && (cnt == CW'(HDR_W - 1));
    assign pay_last = (phase == PH_PAY) && (cnt == CW'(DATA_W - 1));

    // Shift in host bits and keep the bit position within the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt     <= '0;
            phase   <= PH_HDR;
        end else if (!sel) begin
            cnt   <= '0;
            phase <= PH_HDR;
        end else if (rise) begin
            shreg_q <= {shreg_q[SH_W-3:0], mosi_bit};
            if (hdr_last) begin
                cnt   <= '0;
                phase <= PH_PAY;
            end else if (pay_last) begin
                cnt   <= '0;
                phase <= PH_HDR;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Latch the decoded header on its final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_ok   <= 1'b0;
            hdr_rw   <= 1'b0;
            hdr_addr <= '0;
        end else if (sel && rise && hdr_last) begin
            hdr_ok   <= ~hdr_word[HDR_W-1] & hdr_word[0];
            hdr_rw   <= hdr_word[HDR_W-2];
            hdr_addr <= hdr_word[HDR_W-3:1];
        end
    end

    // Commit strobe: last payload bit of a well-formed write frame.
    always_comb begin
        wr_en = sel && rise && pay_last && hdr_ok && !hdr_rw;
    end
endmodule

// File: rtl/cfg_spi_regbank.sv
`timescale 1ns/1ps
// Register bank of 2**ADDR_W entries with one write port and one
// combinational read port. Assumes a single-cycle write strobe.
module cfg_spi_regbank #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One storage word, cleared by reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                mem[g] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cfg_spi_slave.sv
`timescale 1ns/1ps
// Serial configuration slave top: synchronizes the link pins, parses
// two-byte frames, owns the register bank and drives the return line.
// Assumes sck is at least ~10x slower than clk and idles low.
module cfg_spi_slave
    import cfg_spi_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic mosi,
    input  logic cfg_sel_n,
    input  logic dat_sel_n,
    output logic miso,
    output logic miso_en
);
    localparam int HDR_W = ADDR_W + 3;
    localparam int SH_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CW    = $clog2(SH_W);

    logic [3:0]        pins_s;
    logic              sck_s, mosi_s, cfg_req, dat_req, sel_act;
    logic              sck_rise, sck_fall;
    phase_e            phase;
    logic [CW-1:0]     cnt;
    logic              hdr_ok, hdr_rw, wr_en;
    logic [ADDR_W-1:0] hdr_addr;
    logic [DATA_W-1:0] wr_data, rd_data, rd_shift;
    logic              miso_q;

    cfg_spi_sync #(
        .W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({sck, mosi, cfg_sel_n, dat_sel_n}),
        .dout(pins_s)
    );

    assign {sck_s, mosi_s} = pins_s[3:2];
    assign cfg_req = ~pins_s[1];
    assign dat_req = ~pins_s[0];
    assign sel_act = cfg_grant(cfg_req, dat_req);

    cfg_spi_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sck_s),
        .rise(sck_rise), .fall(sck_fall)
    );

    cfg_spi_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .sel(sel_act), .rise(sck_rise),
        .mosi_bit(mosi_s), .phase(phase), .cnt(cnt), .hdr_ok(hdr_ok),
        .hdr_rw(hdr_rw), .hdr_addr(hdr_addr), .wr_en(wr_en),
        .wr_data(wr_data)
    );

    cfg_spi_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(hdr_addr),
        .wr_data(wr_data), .rd_addr(hdr_addr), .rd_data(rd_data)
    );

    // Bit for the current payload position sits at the MSB after shift.
    assign rd_shift = rd_data << cnt;

    // Update the return line on falling sck only; zero outside valid payloads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            miso_q <= 1'b0;
        else if (sel_act && sck_fall)
            miso_q <= (phase == PH_PAY && hdr_ok) ? rd_shift[DATA_W-1] : 1'b0;
    end

    assign miso    = miso_q;
    assign miso_en = sel_act;
endmodule

// File: rtl/cfg_spi_slave_chk.sv
`timescale 1ns/1ps
// Property checker for cfg_spi_slave, attached with bind below.
module cfg_spi_slave_chk #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_act,
    input logic          sck_fall,
    input logic          miso,
    input logic          miso_en,
    input logic          wr_en,
    input logic          hdr_ok,
    input logic          hdr_rw,
    input logic          pay_phase,
    input logic [CW-1:0] cnt
);
    // R9: no drive while deselected
    a_r9_release_line: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |-> !miso_en);

    // R3: return line moves only after a falling serial clock
    a_r3_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(miso));

    // R8: malformed headers and reads never commit
    a_r8_no_bad_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (hdr_ok && !hdr_rw));

    // R5: deselect returns the parser to a fresh header
    a_r5_desel_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> (!pay_phase && cnt == '0));

    // R2: one commit per frame
    a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

bind cfg_spi_slave cfg_spi_slave_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .sck_fall(sck_fall),
    .miso(miso), .miso_en(miso_en), .wr_en(wr_en), .hdr_ok(hdr_ok),
    .hdr_rw(hdr_rw), .pay_phase(phase == cfg_spi_pkg::PH_PAY), .cnt(cnt)
);

// File: tb/cfg_spi_slave_bench.sv
`timescale 1ns/1ps
module cfg_spi_slave_bench;
    localparam int HALF = 40;   // serial half period, 10 system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, cfg_sel_n = 1'b1, dat_sel_n = 1'b1;
    logic miso, miso_en;
    int   total = 0, bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cfg_spi_slave u_cfg_spi_slave (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi),
        .cfg_sel_n(cfg_sel_n), .dat_sel_n(dat_sel_n),
        .miso(miso), .miso_en(miso_en)
    );

    // {rw, index, payload, expected return}
    localparam logic [21:0] VEC [8] = '{
        {1'b0, 5'd3,  8'h5A, 8'h00},
        {1'b0, 5'd3,  8'hC3, 8'h5A},
        {1'b1, 5'd3,  8'h00, 8'hC3},
        {1'b0, 5'd31, 8'hFF, 8'h00},
        {1'b1, 5'd0,  8'h00, 8'h00},
        {1'b0, 5'd0,  8'h81, 8'h00},
        {1'b1, 5'd31, 8'h00, 8'hFF},
        {1'b1, 5'd0,  8'h00, 8'h81}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] hdr(input logic rw, input logic [4:0] idx);
        return {1'b0, rw, idx, 1'b1};
    endfunction

    // Shift n bits (MSB first) and collect what the slave returns.
    task automatic shift_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            #HALF;
            rx[i] = miso;
            sck = 1'b1;
            #HALF;
            sck = 1'b0;
        end
    endtask

    task automatic sel_low();
        cfg_sel_n = 1'b0;
        #HALF;
    endtask

    task automatic sel_high();
        #HALF;
        cfg_sel_n = 1'b1;
        #(2*HALF);
    endtask

    task automatic frame(input logic [7:0] h, input logic [7:0] pay, output logic [7:0] rx);
        logic [7:0] junk;
        sel_low();
        shift_bits(h, 8, junk);
        shift_bits(pay, 8, rx);
        sel_high();
    endtask

    initial begin
        logic [7:0] rx, junk;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        #(4*HALF);

        // R9: released while idle
        check("R9 idle enable", {7'd0, miso_en}, 8'd0);
        // R10: reset contents
        frame(hdr(1'b1, 5'd0), 8'h00, rx);  check("R10 reg0 after reset", rx, 8'h00);
        frame(hdr(1'b1, 5'd31), 8'h00, rx); check("R10 reg31 after reset", rx, 8'h00);

        // R1 R2 R3 R4: table walk, one frame per select
        for (int k = 0; k < 8; k++) begin
            frame(hdr(VEC[k][21], VEC[k][20:16]), VEC[k][15:8], rx);
            check(VEC[k][21] ? "R3 R1 read vector" : "R4 R2 write vector", rx, VEC[k][7:0]);
        end

        // R6: chained frames under one select, R9 enable while selected
        sel_low();
        check("R9 enable while selected", {7'd0, miso_en}, 8'd1);
        shift_bits(hdr(1'b0, 5'd5), 8, junk); shift_bits(8'h11, 8, rx);
        check("R6 chain first write", rx, 8'h00);
        shift_bits(hdr(1'b0, 5'd5), 8, junk); shift_bits(8'h22, 8, rx);
        check("R6 chain second write old value", rx, 8'h11);
        shift_bits(hdr(1'b1, 5'd5), 8, junk); shift_bits(8'h00, 8, rx);
        check("R6 chain read", rx, 8'h22);
        sel_high();

        // R8: bad start bit, then bad stop bit
        frame(8'b1_0_00011_1, 8'h00, rx); check("R8 bad start miso", rx, 8'h00);
        frame(hdr(1'b1, 5'd3), 8'h00, rx); check("R8 bad start no write", rx, 8'hC3);
        frame(8'b0_0_00011_0, 8'h55, rx); check("R8 bad stop miso", rx, 8'h00);
        frame(hdr(1'b1, 5'd3), 8'h00, rx); check("R8 bad stop no write", rx, 8'hC3);
        // R8: bad header inside a chain, next byte is still a header
        sel_low();
        shift_bits(8'b1_0_00011_1, 8, junk); shift_bits(8'h00, 8, junk);
        shift_bits(hdr(1'b1, 5'd3), 8, junk); shift_bits(8'h00, 8, rx);
        sel_high();
        check("R8 header after bad frame", rx, 8'hC3);

        // R5: deselect after header
        sel_low(); shift_bits(hdr(1'b0, 5'd7), 8, junk); sel_high();
        frame(hdr(1'b1, 5'd3), 8'h00, rx); check("R5 next byte is header", rx, 8'hC3);
        frame(hdr(1'b1, 5'd7), 8'h00, rx); check("R5 dropped write", rx, 8'h00);
        // R5: deselect mid-byte
        sel_low(); shift_bits(8'hFF, 4, junk); sel_high();
        frame(hdr(1'b1, 5'd31), 8'h00, rx); check("R5 mid-byte restart", rx, 8'hFF);

        // R11: nonzero payload during a read
        frame(hdr(1'b1, 5'd31), 8'hA5, rx); check("R11 read returns", rx, 8'hFF);
        frame(hdr(1'b1, 5'd31), 8'h00, rx); check("R11 read no write", rx, 8'hFF);

        // R7: data select low has no effect
        dat_sel_n = 1'b0;
        #(2*HALF);
        check("R7 idle enable with data select", {7'd0, miso_en}, 8'd0);
        frame(hdr(1'b0, 5'd9), 8'h3C, rx); check("R7 write with data select", rx, 8'h00);
        frame(hdr(1'b1, 5'd9), 8'h00, rx); check("R7 read with data select", rx, 8'h3C);
        dat_sel_n = 1'b1;

        // R10: reset mid-run clears stored values
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(2*HALF);
        frame(hdr(1'b1, 5'd3), 8'h00, rx); check("R10 clear after reset", rx, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule